// File: doc/BRIEF.md
# Extended Control Window with Test FIFO

This block is a second byte-wide register window beside a parallel port. It keeps a control register that selects one of eight operating modes and shows the fill state of a small test FIFO, a configuration byte, and a plain data byte. Data transfer engines are not part of it. The block only holds the registers, which makes the FIFO and its flags visible to the host.

The FIFO can be reached through offset 0 only while the FIFO-test mode is selected. A write there pushes a byte, and a read there pops one. In every other mode, offset 0 is an ordinary storage byte. Any write that changes the mode field empties the FIFO. The host can therefore push bytes, read the flags in the control register, and pop the bytes again to exercise the queue.

Top module: `xctl_window`

## Requirements
- R1: Every access is one byte at a 3-bit offset, and at most one of `wr_en` and `rd_en` is high in a cycle. Read data is valid on `rdata` while `rd_en` is high, and every side effect of an access takes place at the next rising clock edge.
- R2: The control register at offset 2 reads back as {mode[7:5], stored bits[4:2], flags[1:0]}. The flag codes are 01 for empty, 10 for full and 00 for partly filled. The value 11 never appears.
- R3: After reset the control register reads 0x01 (compatibility mode, empty), and the configuration and plain data bytes read 0x00.
- R4: When the mode is not FIFO test, offset 0 is a read/write byte and a read of it changes nothing. Pushes made in FIFO-test mode leave this byte unchanged.
- R5: A write to offset 2 replaces the mode field with bits [7:5] of the written value and stores bits [4:2] as written. Bits [1:0] of the written value are ignored. The mode codes are 0 compatibility, 1 byte, 2 port FIFO, 3 extended FIFO, 4 address/data, 5 reserved, 6 FIFO test and 7 configuration.
- R6: Offset 1 is a read/write configuration byte, and a change of mode does not alter it.
- R7: A write to offset 2 whose mode differs from the current mode resets both FIFO positions and sets the flags to empty. A write that keeps the same mode leaves the FIFO and its flags untouched.
- R8: The FIFO is 2 bytes deep with separate read and write positions. In FIFO-test mode, a push sets the flags to partly filled, or to full when the write position reaches the depth, and the write position then wraps to 0. A pop returns the byte at the read position and advances it, wrapping at the depth. The flags then read empty if the read position equals the write position, and partly filled otherwise.
- R9: A push while the flags read full is ignored. A pop while the flags read empty returns 0xFF and changes nothing.
- R10: Offsets 3 to 7 read 0xFF, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| rd_en | input | 1 | Read strobe for one byte |
| addr | input | 3 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and a FIFO depth of 2. With a depth of 2, the full flag, the ignored push at full, and the wrap of both positions are each reached within two or three accesses. The bench also follows a push/pop/push sequence in which the write position wraps while only one byte is held, and checks that the flags still follow the position rule.

// File: rtl/xctl_pkg.sv
package xctl_pkg;
   typedef enum logic [2:0] {
      MODE_COMPAT   = 3'd0,
      MODE_BYTE     = 3'd1,
      MODE_PPFIFO   = 3'd2,
      MODE_XFIFO    = 3'd3,
      MODE_ADDRDATA = 3'd4,
      MODE_RSVD     = 3'd5,
      MODE_FTEST    = 3'd6,
      MODE_CONFIG   = 3'd7
   } xmode_e;

   typedef enum logic [1:0] {
      FLG_PARTIAL = 2'b00,
      FLG_EMPTY   = 2'b01,
      FLG_FULL    = 2'b10
   } fflag_e;

   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_CFG  = 3'd1;
   localparam logic [2:0] OFS_CTL  = 3'd2;
endpackage

// File: rtl/xctl_fifo.sv
module xctl_fifo
   import xctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              flush_i,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output fflag_e            flags_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("xctl_fifo: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   logic [PTR_W-1:0]  wptr_nx, rptr_nx;
   logic              w_wrap, r_wrap;
   fflag_e            flags_q;
   logic              do_push, do_pop;

   assign do_push = push_i && !flush_i && (flags_q != FLG_FULL);
   assign do_pop  = pop_i && !flush_i && (flags_q != FLG_EMPTY);

   if (POW2) begin : g_wrap_carry
      logic [PTR_W:0] w_inc, r_inc;
      assign w_inc   = {1'b0, wptr_q} + 1'b1;
      assign r_inc   = {1'b0, rptr_q} + 1'b1;
      assign w_wrap  = w_inc[PTR_W];
      assign r_wrap  = r_inc[PTR_W];
      assign wptr_nx = w_inc[PTR_W-1:0];
      assign rptr_nx = r_inc[PTR_W-1:0];
   end else begin : g_wrap_cmp
      localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
      assign w_wrap  = (wptr_q == LAST);
      assign r_wrap  = (rptr_q == LAST);
      assign wptr_nx = w_wrap ? '0 : wptr_q + 1'b1;
      assign rptr_nx = r_wrap ? '0 : rptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         flags_q <= FLG_EMPTY;
      end else if (flush_i) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         flags_q <= FLG_EMPTY;
      end else if (do_push) begin
         wptr_q  <= wptr_nx;
         flags_q <= w_wrap ? FLG_FULL : FLG_PARTIAL;
      end else if (do_pop) begin
         rptr_q  <= rptr_nx;
         flags_q <= (rptr_nx == wptr_q) ? FLG_EMPTY : FLG_PARTIAL;
      end
   end

   assign dout    = (flags_q == FLG_EMPTY) ? '1 : mem[rptr_q];
   assign flags_o = flags_q;

   assert_flags_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q != fflag_e'(2'b11));

   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (flags_q == FLG_EMPTY && wptr_q == '0 && rptr_q == '0));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !flush_i && flags_q == FLG_FULL) |=> (flags_q == FLG_FULL && $stable(wptr_q)));

   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !flush_i && flags_q == FLG_EMPTY) |=> (flags_q == FLG_EMPTY && $stable(rptr_q)));
endmodule

// File: rtl/xctl_regs.sv
module xctl_regs
   import xctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output xmode_e            mode_o,
   output logic [DATA_W-6:0] mid_o,
   output logic [DATA_W-1:0] cfg_o,
   output logic [DATA_W-1:0] plain_o,
   output logic              test_o,
   output logic              flush_o
);
   localparam int MID_W = DATA_W - 5;

   if (DATA_W < 6) begin : g_bad_width
      $error("xctl_regs: DATA_W must leave room for mode and flags");
   end

   xmode_e            mode_q, mode_wr;
   logic [MID_W-1:0]  mid_q;
   logic [DATA_W-1:0] cfg_q, plain_q;
   logic              ctl_wr;

   assign mode_wr = xmode_e'(wdata[DATA_W-1 -: 3]);
   assign ctl_wr  = wr_en && (addr == OFS_CTL);
   assign test_o  = (mode_q == MODE_FTEST);
   assign flush_o = ctl_wr && (mode_wr != mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_COMPAT;
         mid_q   <= '0;
         cfg_q   <= '0;
         plain_q <= '0;
      end else if (wr_en) begin
         case (addr)
            OFS_DATA: if (!test_o) plain_q <= wdata;
            OFS_CFG:  cfg_q <= wdata;
            OFS_CTL: begin
               mode_q <= mode_wr;
               mid_q  <= wdata[DATA_W-4:2];
            end
            default: ;
         endcase
      end
   end

   assign mode_o  = mode_q;
   assign mid_o   = mid_q;
   assign cfg_o   = cfg_q;
   assign plain_o = plain_q;

   assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(mode_q));

   assert_plain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && test_o) |=> $stable(plain_q));
endmodule

// File: rtl/xctl_window.sv
module xctl_window
   import xctl_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int MID_W = DATA_W - 5;

   xmode_e            mode;
   logic [MID_W-1:0]  mid;
   logic [DATA_W-1:0] cfg, plain, fifo_dout;
   logic              test, flush, push, pop;
   fflag_e            flags;

   xctl_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .mode_o(mode), .mid_o(mid), .cfg_o(cfg), .plain_o(plain),
      .test_o(test), .flush_o(flush)
   );

   assign push = wr_en && (addr == OFS_DATA) && test;
   assign pop  = rd_en && (addr == OFS_DATA) && test;

   xctl_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .flush_i(flush),
      .din(wdata), .dout(fifo_dout), .flags_o(flags)
   );

   always_comb begin
      case (addr)
         OFS_DATA: rdata = test ? fifo_dout : plain;
         OFS_CFG:  rdata = cfg;
         OFS_CTL:  rdata = {mode, mid, flags};
         default:  rdata = '1;
      endcase
   end

   assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));
endmodule

// File: tb/xctl_window_test.sv
module xctl_window_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xctl_window uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(3'd2, v); check("R3 ctl at reset", v, 8'h01);
      rd(3'd1, v); check("R3 cfg at reset", v, 8'h00);
      rd(3'd0, v); check("R3 plain at reset", v, 8'h00);
   endtask

   task automatic t_plain_regs;
      logic [7:0] v;
      wr(3'd1, 8'hA5); rd(3'd1, v); check("R6 cfg readback", v, 8'hA5);
      wr(3'd0, 8'h3C); rd(3'd0, v); check("R4 plain readback", v, 8'h3C);
      rd(3'd0, v); check("R4 plain reread", v, 8'h3C);
      for (int a = 3; a < 8; a++) begin
         wr(3'(a), 8'h00); rd(3'(a), v); check("R10 unused offset", v, 8'hFF);
      end
      rd(3'd1, v); check("R10 cfg untouched", v, 8'hA5);
      rd(3'd0, v); check("R10 plain untouched", v, 8'h3C);
   endtask

   task automatic t_fifo_fill;
      logic [7:0] v;
      wr(3'd2, 8'hDF); rd(3'd2, v); check("R5 mode write, flags read-only", v, 8'hDD);
      rd(3'd0, v); check("R9 pop empty returns FF", v, 8'hFF);
      rd(3'd2, v); check("R9 still empty", v, 8'hDD);
      wr(3'd0, 8'h11); rd(3'd2, v); check("R8 partly after push", v, 8'hDC);
      wr(3'd0, 8'h22); rd(3'd2, v); check("R8 full at depth", v, 8'hDE);
      wr(3'd0, 8'h33); rd(3'd2, v); check("R9 push at full ignored", v, 8'hDE);
      rd(3'd0, v); check("R8 first pop", v, 8'h11);
      rd(3'd2, v); check("R8 partly after pop", v, 8'hDC);
      rd(3'd0, v); check("R9 overflow byte dropped", v, 8'h22);
      rd(3'd2, v); check("R8 empty after pops", v, 8'hDD);
      rd(3'd0, v); check("R9 pop empty again", v, 8'hFF);
   endtask

   task automatic t_mode_change;
      logic [7:0] v;
      wr(3'd0, 8'h44);
      wr(3'd2, 8'h1C); rd(3'd2, v); check("R7 flush on mode change, R5 replace", v, 8'h1D);
      rd(3'd0, v); check("R4 plain kept across test pushes", v, 8'h3C);
      rd(3'd1, v); check("R6 cfg kept across modes", v, 8'hA5);
      wr(3'd2, 8'hC0); rd(3'd0, v); check("R7 flushed byte gone", v, 8'hFF);
      wr(3'd0, 8'h55);
      wr(3'd2, 8'hC0); rd(3'd2, v); check("R7 same mode no flush", v, 8'hC0);
      rd(3'd0, v); check("R7 byte survives same-mode write", v, 8'h55);
      wr(3'd0, 8'h77); rd(3'd2, v); check("R8 full after write wrap", v, 8'hC2);
      rd(3'd0, v); check("R8 pop across read wrap", v, 8'h77);
      rd(3'd2, v); check("R8 empty when positions meet", v, 8'hC1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain_regs();
      t_fifo_fill();
      t_mode_change();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule